// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired sequencer for a multicycle 32-bit load/store datapath in which one memory and one ALU are shared across the steps of each instruction. Every instruction starts in a common fetch step and then a common decode step. After that it follows a fixed path of 4-bit states chosen by its 6-bit opcode, and the last state of every path returns to fetch. In each state the block drives the datapath control points directly from the state code. These are the register, memory and PC write enables, the memory address select, the two ALU operand selects and the 2-bit ALU operation code.

Five instruction classes are sequenced: register-to-register arithmetic, OR with an immediate, load word, store word and branch-if-equal. The decode step always puts the branch target, PC plus the sign-extended immediate shifted left by 2, into the ALU output register, so that the branch itself needs only one more state. The conditional PC write is combined with the ALU zero flag into a single PC load strobe for the datapath.

Top module: `mc_ctrl`

## Requirements
- R1: The reset is synchronous. A clock edge with `rst` high puts `state` at 0000. While `rst` is high, `ir_we`, `pc_we`, `pc_we_cond`, `pc_load`, `mem_rd`, `mem_we` and `rf_we` are all low. The first state after reset is released is 0000.
- R2: State 0000 (fetch) sets `mem_rd`=1, `addr_sel`=0 (PC), `ir_we`=1, `pc_we`=1, `pc_src`=0 (ALU result), `opa_sel`=0 (PC), `opb_sel`=001 and `alu_op`=00. The next state is always 0001.
- R3: State 0001 (decode) sets `opa_sel`=0, `opb_sel`=011, `alu_op`=00 and no write enable. The next state is chosen by `opcode`: 0x00 goes to 0100, 0x0D to 0110, 0x23 to 1000, 0x2B to 1011 and 0x04 to 0010. Any other opcode goes back to 0000.
- R4: Register-type path: 0100 sets `opa_sel`=1 (register A), `opb_sel`=000 and `alu_op`=10. Then 0101 sets `rf_we`=1, `rf_dst`=1 (rd) and `rf_src`=0 (ALUout).
- R5: OR-immediate path: 0110 sets `opa_sel`=1, `opb_sel`=100 and `alu_op`=11. Then 0111 sets `rf_we`=1, `rf_dst`=0 (rt) and `rf_src`=0.
- R6: Load path: 1000 sets `opa_sel`=1, `opb_sel`=010 and `alu_op`=00. Then 1001 sets `mem_rd`=1 and `addr_sel`=1 (ALUout). Then 1010 sets `rf_we`=1, `rf_dst`=0 and `rf_src`=1 (memory data).
- R7: Store path: 1011 sets `opa_sel`=1, `opb_sel`=010 and `alu_op`=00. Then 1100 sets `mem_we`=1 and `addr_sel`=1.
- R8: Branch state 0010 sets `opa_sel`=1, `opb_sel`=000, `alu_op`=01, `pc_we_cond`=1 and `pc_src`=1 (ALUout). `pc_load` is high in 0010 exactly when `alu_zero` is high. In every other state `pc_load` equals `pc_we`, whatever the value of `alu_zero`.
- R9: Every state not named in R2 to R8 drives every control to 0. The final state of each path (0101, 0111, 1010, 1100, 0010), and each unused code, is followed by 0000. `opcode` has no effect in any state other than 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_zero | input | 1 | ALU result-is-zero flag |
| state | output | 4 | Current state code |
| ir_we | output | 1 | Instruction register load |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write if ALU zero |
| pc_load | output | 1 | Combined PC load strobe |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALUout |
| mem_rd | output | 1 | Memory read |
| mem_we | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUout |
| rf_we | output | 1 | Register file write |
| rf_dst | output | 1 | Destination: 0 rt, 1 rd |
| rf_src | output | 1 | Write data: 0 ALUout, 1 memory data |
| opa_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| opb_sel | output | 3 | ALU operand B select |
| alu_op | output | 2 | ALU operation code |

## Verification
The opcode fed at each decode step cycles through all five known classes and two unrecognised codes. This separates each dispatch target and shows the fallback to fetch. While a path is running, the opcode is replaced with junk values, which shows that only the decode step looks at it. `alu_zero` is toggled at random every cycle, so a taken branch can be told apart from a not-taken one, and a zero flag that leaks into `pc_load` outside the branch state is caught. A reset in the middle of the run, asserted while a path is in progress, shows that the write enables are forced low during reset and that the sequence restarts from fetch.

// File: rtl/mc_ctrl.sv
module mc_ctrl #(
  parameter logic [5:0] OP_RTYPE = 6'h00,
  parameter logic [5:0] OP_ORI   = 6'h0d,
  parameter logic [5:0] OP_LW    = 6'h23,
  parameter logic [5:0] OP_SW    = 6'h2b,
  parameter logic [5:0] OP_BEQ   = 6'h04
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic       alu_zero,
  output logic [3:0] state,
  output logic       ir_we,
  output logic       pc_we,
  output logic       pc_we_cond,
  output logic       pc_load,
  output logic       pc_src,
  output logic       mem_rd,
  output logic       mem_we,
  output logic       addr_sel,
  output logic       rf_we,
  output logic       rf_dst,
  output logic       rf_src,
  output logic       opa_sel,
  output logic [2:0] opb_sel,
  output logic [1:0] alu_op
);

  typedef enum logic [3:0] {
    S_FETCH  = 4'b0000,
    S_DECODE = 4'b0001,
    S_BRANCH = 4'b0010,
    S_RCALC  = 4'b0100,
    S_RWB    = 4'b0101,
    S_OCALC  = 4'b0110,
    S_OWB    = 4'b0111,
    S_LADDR  = 4'b1000,
    S_LMEM   = 4'b1001,
    S_LWB    = 4'b1010,
    S_SADDR  = 4'b1011,
    S_SMEM   = 4'b1100
  } st_t;

  localparam logic [1:0] ALU_ADD = 2'b00;
  localparam logic [1:0] ALU_SUB = 2'b01;
  localparam logic [1:0] ALU_FN  = 2'b10;
  localparam logic [1:0] ALU_OR  = 2'b11;

  localparam logic [2:0] B_RT   = 3'b000;
  localparam logic [2:0] B_FOUR = 3'b001;
  localparam logic [2:0] B_SX   = 3'b010;
  localparam logic [2:0] B_SXS2 = 3'b011;
  localparam logic [2:0] B_ZX   = 3'b100;

  st_t cur, nxt;

  logic ir_w, pc_w, pc_wc, m_rd, m_we, r_we;

  always_ff @(posedge clk) begin
    if (rst) cur <= S_FETCH;
    else     cur <= nxt;
  end

  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        if      (opcode == OP_RTYPE) nxt = S_RCALC;
        else if (opcode == OP_ORI)   nxt = S_OCALC;
        else if (opcode == OP_LW)    nxt = S_LADDR;
        else if (opcode == OP_SW)    nxt = S_SADDR;
        else if (opcode == OP_BEQ)   nxt = S_BRANCH;
        else                         nxt = S_FETCH;
      end
      S_RCALC:  nxt = S_RWB;
      S_OCALC:  nxt = S_OWB;
      S_LADDR:  nxt = S_LMEM;
      S_LMEM:   nxt = S_LWB;
      S_SADDR:  nxt = S_SMEM;
      default:  nxt = S_FETCH;
    endcase
  end

  always_comb begin
    ir_w = 1'b0; pc_w = 1'b0; pc_wc = 1'b0; m_rd = 1'b0; m_we = 1'b0; r_we = 1'b0;
    pc_src = 1'b0; addr_sel = 1'b0; rf_dst = 1'b0; rf_src = 1'b0;
    opa_sel = 1'b0; opb_sel = B_RT; alu_op = ALU_ADD;
    case (cur)
      S_FETCH: begin
        m_rd = 1'b1; ir_w = 1'b1; pc_w = 1'b1;
        opb_sel = B_FOUR; alu_op = ALU_ADD;
      end
      S_DECODE: begin
        opb_sel = B_SXS2; alu_op = ALU_ADD;
      end
      S_BRANCH: begin
        opa_sel = 1'b1; opb_sel = B_RT; alu_op = ALU_SUB;
        pc_wc = 1'b1; pc_src = 1'b1;
      end
      S_RCALC: begin
        opa_sel = 1'b1; opb_sel = B_RT; alu_op = ALU_FN;
      end
      S_RWB: begin
        r_we = 1'b1; rf_dst = 1'b1;
      end
      S_OCALC: begin
        opa_sel = 1'b1; opb_sel = B_ZX; alu_op = ALU_OR;
      end
      S_OWB:   r_we = 1'b1;
      S_LADDR, S_SADDR: begin
        opa_sel = 1'b1; opb_sel = B_SX; alu_op = ALU_ADD;
      end
      S_LMEM: begin
        m_rd = 1'b1; addr_sel = 1'b1;
      end
      S_LWB: begin
        r_we = 1'b1; rf_src = 1'b1;
      end
      S_SMEM: begin
        m_we = 1'b1; addr_sel = 1'b1;
      end
      default: ;
    endcase
  end

  assign state      = cur;
  assign ir_we      = ir_w  & ~rst;
  assign pc_we      = pc_w  & ~rst;
  assign pc_we_cond = pc_wc & ~rst;
  assign mem_rd     = m_rd  & ~rst;
  assign mem_we     = m_we  & ~rst;
  assign rf_we      = r_we  & ~rst;
  assign pc_load    = pc_we | (pc_we_cond & alu_zero);

  p_decode_follows_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> state == S_DECODE);

  p_unknown_op_refetch_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE && opcode != OP_RTYPE && opcode != OP_ORI && opcode != OP_LW &&
     opcode != OP_SW && opcode != OP_BEQ) |=> state == S_FETCH);

  p_store_after_addr_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (addr_sel && $past(state) == S_SADDR));

  p_mem_single_access_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_we}));

  p_branch_compares_r8: assert property (@(posedge clk) disable iff (rst)
    pc_we_cond |-> (alu_op == ALU_SUB && pc_src && !pc_we));

  p_writeback_returns_r9: assert property (@(posedge clk) disable iff (rst)
    (rf_we || mem_we || pc_we_cond) |=> state == S_FETCH);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> !(ir_we || pc_we || pc_we_cond || pc_load || mem_rd || mem_we || rf_we));

endmodule

// File: tb/test_mc_ctrl.sv
`timescale 1ns/1ps
module test_mc_ctrl;
  logic clk = 1'b0;
  logic rst;
  logic [5:0] opcode;
  logic alu_zero;
  logic [3:0] state;
  logic ir_we, pc_we, pc_we_cond, pc_load, pc_src, mem_rd, mem_we, addr_sel;
  logic rf_we, rf_dst, rf_src, opa_sel;
  logic [2:0] opb_sel;
  logic [1:0] alu_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mc_ctrl i_mc_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero), .state(state),
    .ir_we(ir_we), .pc_we(pc_we), .pc_we_cond(pc_we_cond), .pc_load(pc_load),
    .pc_src(pc_src), .mem_rd(mem_rd), .mem_we(mem_we), .addr_sel(addr_sel),
    .rf_we(rf_we), .rf_dst(rf_dst), .rf_src(rf_src), .opa_sel(opa_sel),
    .opb_sel(opb_sel), .alu_op(alu_op)
  );

  logic [20:0] got;
  assign got = {state, ir_we, pc_we, pc_we_cond, pc_load, pc_src, mem_rd, mem_we,
                addr_sel, rf_we, rf_dst, rf_src, opa_sel, opb_sel, alu_op};

  function automatic logic [20:0] model_out(int s, bit z, bit r);
    bit ir = 0, pw = 0, pwc = 0, ps = 0, mr = 0, mw = 0, asel = 0;
    bit rw = 0, rd = 0, rs = 0, oa = 0;
    logic [2:0] ob = 3'd0;
    logic [1:0] op = 2'd0;
    case (s)
      0:  begin mr = 1; ir = 1; pw = 1; ob = 3'd1; end
      1:  ob = 3'd3;
      2:  begin oa = 1; op = 2'd1; pwc = 1; ps = 1; end
      4:  begin oa = 1; op = 2'd2; end
      5:  begin rw = 1; rd = 1; end
      6:  begin oa = 1; ob = 3'd4; op = 2'd3; end
      7:  rw = 1;
      8:  begin oa = 1; ob = 3'd2; end
      9:  begin mr = 1; asel = 1; end
      10: begin rw = 1; rs = 1; end
      11: begin oa = 1; ob = 3'd2; end
      12: begin mw = 1; asel = 1; end
      default: ;
    endcase
    if (r) begin ir = 0; pw = 0; pwc = 0; mr = 0; mw = 0; rw = 0; end
    return {4'(s), ir, pw, pwc, pw | (pwc & z), ps, mr, mw, asel, rw, rd, rs, oa, ob, op};
  endfunction

  function automatic int model_next(int s, logic [5:0] op, bit r);
    if (r) return 0;
    case (s)
      0: return 1;
      1: case (op)
           6'h00: return 4;
           6'h0d: return 6;
           6'h23: return 8;
           6'h2b: return 11;
           6'h04: return 2;
           default: return 0;
         endcase
      4: return 5;
      6: return 7;
      8: return 9;
      9: return 10;
      11: return 12;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int s, bit r);
    if (r) return "R1";
    case (s)
      0: return "R2/R9";
      1: return "R3";
      4, 5: return "R4";
      6, 7: return "R5";
      8, 9, 10: return "R6";
      11, 12: return "R7";
      2: return "R8";
      default: return "R9";
    endcase
  endfunction

  int ms = 0;
  int idx = 0;
  logic [5:0] ops [7] = '{6'h00, 6'h0d, 6'h23, 6'h2b, 6'h04, 6'h3f, 6'h02};

  task automatic compare();
    logic [20:0] e;
    e = model_out(ms, alu_zero, rst);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s state %0d: got %b expected %b", tag_of(ms, rst), ms, got, e);
    end
  endtask

  initial begin
    rst = 1'b1; opcode = 6'h00; alu_zero = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ms = 0;
    for (int cyc = 0; cyc < 600; cyc++) begin
      compare();
      rst = (cyc < 2) || (cyc >= 300 && cyc < 303);
      alu_zero = 1'($urandom_range(0, 1));
      if (ms == 0) begin
        opcode = ops[idx % 7];
        idx++;
      end else if (ms != 1) begin
        opcode = 6'($urandom_range(0, 63));
      end
      ms = model_next(ms, opcode, rst);
      @(negedge clk);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule